// File: doc/BRIEF.md
# Double-Buffered Serial Frame Receiver

This block receives asynchronous serial characters on one input line. An oversampling tick sets the sampling rate. The receiver finds each start bit, takes 5 to 9 data bits least significant bit first, and checks an optional even or odd parity bit and the first stop bit. Each finished character goes into a two-entry receive queue. The character is stored together with its ninth bit and its own frame, parity and overrun flags.

A host reads the queue from the output side. The outputs always show the oldest unread character and its flags. A one-cycle read strobe removes that character. A third completed character can wait in the shift stage while the queue is full. If a fourth start bit then arrives, that waiting character is marked as overrun and the incoming frame is lost. In multiprocessor mode, frames that do not carry an address mark are discarded. Clearing the enable input empties everything at once.

Top module: `serial_frame_rx`

## Requirements
- R1: `avail_o` is 1 exactly while the queue holds unread characters. A cycle with `rd_i` high and `avail_o` high removes the oldest character. Up to two characters are held and are read back in the order they arrived.
- R2: `len_sel_i` selects the data bits per frame: 000=5, 001=6, 010=7, 011=8, 111=9, and any other code gives 8. Data bits arrive least significant bit first. `data_o` holds bits 7:0 with any unused upper bits at 0. `bit9_o` holds the ninth bit in 9-bit frames and is 0 otherwise. It belongs to the same entry as `data_o`, so it must be read before the strobe removes that entry.
- R3: `par_sel_i` 10 selects even parity and 11 selects odd parity. In both modes one parity bit follows the data. Codes 00 and 01 mean no parity bit. If the received parity bit does not match, `par_err_o` is set for that character.
- R4: `frm_err_o` is set for a character whose first stop bit is sampled as 0. No second stop bit is checked: a start bit directly after the first stop bit is received as a new frame.
- R5: The flags shown belong to the character at the head of the queue. They stay until that character is read. When `avail_o` is 0, `data_o`, `bit9_o` and all three flags read 0.
- R6: An overrun occurs when the queue is full, a completed character waits in the shift stage, and a new start bit is confirmed. The waiting character then carries `ovr_o`=1 when it reaches the head, and the incoming frame is dropped.
- R7: While `rx_en_i` is 0, the queue and the shift stage are emptied and all flags are cleared. `avail_o` is 0 from the next cycle on.
- R8: One bit lasts 16 `tick_i` pulses when `dbl_speed_i`=0 and 8 pulses when it is 1. Cycles without a tick do not advance the receiver.
- R9: A start bit is accepted only if the line is still low at mid-bit. A shorter low pulse produces no character. Each data, parity and stop bit is the majority of three samples around the bit centre.
- R10: With `mp_mode_i`=1, a frame whose last data bit (the ninth bit in 9-bit frames) is 0 does not enter the queue.
- R11: `irq_o` equals `avail_o` AND `rx_ie_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable; low flushes all state |
| tick_i | input | 1 | Oversampling tick |
| dbl_speed_i | input | 1 | 8 ticks per bit instead of 16 |
| len_sel_i | input | 3 | Character length code |
| par_sel_i | input | 2 | Parity mode code |
| mp_mode_i | input | 1 | Multiprocessor address filter |
| rx_ie_i | input | 1 | Interrupt enable |
| rxd_i | input | 1 | Serial line input |
| rd_i | input | 1 | Read strobe, removes head entry |
| data_o | output | 8 | Head character bits 7:0 |
| bit9_o | output | 1 | Head character ninth bit |
| avail_o | output | 1 | Unread data present |
| frm_err_o | output | 1 | Head character frame error |
| ovr_o | output | 1 | Head character overrun |
| par_err_o | output | 1 | Head character parity error |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The overrun mark is the hardest state to reach from the ports. It needs two unread characters in the queue, a third one finished and waiting in the shift stage, and then a fourth start bit that gets past the mid-bit check. The stimulus sends four back-to-back frames without reading. It then reads out three entries and expects the flag only on the third. It also confirms that the fourth character never appears.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       b9;
    logic       fe;
    logic       pe;
    logic       ovr;
  } rx_char_t;

  function automatic logic [3:0] len_bits(input logic [2:0] code);
    case (code)
      3'b000:  len_bits = 4'd5;
      3'b001:  len_bits = 4'd6;
      3'b010:  len_bits = 4'd7;
      3'b111:  len_bits = 4'd9;
      default: len_bits = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '1;
    else         q_q <= {q_q[STAGES-2:0], d_i};
  end

  assign q_o = q_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     tick_i,
  input  logic     dbl_i,
  input  logic [3:0] nbits_i,
  input  logic     par_en_i,
  input  logic     par_odd_i,
  input  logic     rx_i,
  output logic     start_o,
  output logic     done_o,
  output logic     addr_o,
  output rx_char_t char_o
);
  localparam int OSR_DBL = OSR / 2;
  localparam int CW      = $clog2(OSR + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t          st_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]   hist_q;
  logic [3:0]   idx_q;
  logic [8:0]   sh_q;
  logic         acc_q, pbit_q, armed_q;
  logic         start_q, done_q, addr_q;
  rx_char_t     char_q;

  logic [CW-1:0] half, dec;
  logic          maj;
  logic [3:0]    last_idx;

  assign half     = dbl_i ? CW'(OSR_DBL / 2 - 1) : CW'(OSR / 2 - 1);
  assign dec      = dbl_i ? CW'(OSR_DBL) : CW'(OSR);
  assign maj      = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx_i) | (hist_q[0] & rx_i);
  assign last_idx = nbits_i - 4'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      hist_q  <= '1;
      idx_q   <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      pbit_q  <= 1'b0;
      armed_q <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= 1'b0;
      char_q  <= '0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      if (!en_i) begin
        st_q    <= S_IDLE;
        armed_q <= 1'b0;
      end else if (tick_i) begin
        hist_q <= {hist_q[0], rx_i};
        unique case (st_q)
          S_IDLE: begin
            if (rx_i) armed_q <= 1'b1;
            else if (armed_q) begin
              st_q  <= S_START;
              cnt_q <= CW'(1);
            end
          end
          S_START: begin
            if (cnt_q == half) begin
              if (rx_i) st_q <= S_IDLE;
              else begin
                st_q    <= S_DATA;
                cnt_q   <= '0;
                idx_q   <= '0;
                sh_q    <= '0;
                acc_q   <= 1'b0;
                start_q <= 1'b1;
              end
            end else cnt_q <= cnt_q + CW'(1);
          end
          S_DATA: begin
            if (cnt_q == dec) begin
              cnt_q       <= CW'(1);
              sh_q[idx_q] <= maj;
              acc_q       <= acc_q ^ maj;
              if (idx_q == last_idx) st_q <= par_en_i ? S_PAR : S_STOP;
              else                   idx_q <= idx_q + 4'd1;
            end else cnt_q <= cnt_q + CW'(1);
          end
          S_PAR: begin
            if (cnt_q == dec) begin
              cnt_q  <= CW'(1);
              pbit_q <= maj;
              st_q   <= S_STOP;
            end else cnt_q <= cnt_q + CW'(1);
          end
          S_STOP: begin
            if (cnt_q == dec) begin
              st_q        <= S_IDLE;
              armed_q     <= maj;
              done_q      <= 1'b1;
              addr_q      <= sh_q[last_idx];
              char_q.data <= sh_q[7:0];
              char_q.b9   <= sh_q[8];
              char_q.fe   <= ~maj;
              char_q.pe   <= par_en_i & (pbit_q != (acc_q ^ par_odd_i));
              char_q.ovr  <= 1'b0;
            end else cnt_q <= cnt_q + CW'(1);
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign start_o = start_q;
  assign done_o  = done_q;
  assign addr_o  = addr_q;
  assign char_o  = char_q;
endmodule

// File: rtl/rx_buf.sv
module rx_buf
  import rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     flush_i,
  input  logic     push_i,
  input  rx_char_t push_data_i,
  input  logic     pop_i,
  output logic     full_o,
  output logic     empty_o,
  output rx_char_t head_o
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  rx_char_t        mem_q [DEPTH];
  logic [PW-1:0]   wr_q, rd_q;
  logic [CNTW-1:0] cnt_q;
  logic            do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    nxt = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o  = (cnt_q == CNTW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= push_data_i;
        wr_q        <= nxt(wr_q);
      end
      if (do_pop) rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CNTW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CNTW'(1);
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_en_i,
  input  logic       tick_i,
  input  logic       dbl_speed_i,
  input  logic [2:0] len_sel_i,
  input  logic [1:0] par_sel_i,
  input  logic       mp_mode_i,
  input  logic       rx_ie_i,
  input  logic       rxd_i,
  input  logic       rd_i,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       avail_o,
  output logic       frm_err_o,
  output logic       ovr_o,
  output logic       par_err_o,
  output logic       irq_o
);
  logic     rx_s, start, done, addr, full, empty;
  rx_char_t fr_char, head, pend_q;
  logic     pend_v_q, drop_q, accept;

  rx_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  rx_frame #(.OSR(OSR)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (rx_en_i),
    .tick_i   (tick_i),
    .dbl_i    (dbl_speed_i),
    .nbits_i  (len_bits(len_sel_i)),
    .par_en_i (par_sel_i[1]),
    .par_odd_i(par_sel_i[0]),
    .rx_i     (rx_s),
    .start_o  (start),
    .done_o   (done),
    .addr_o   (addr),
    .char_o   (fr_char)
  );

  rx_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (~rx_en_i),
    .push_i     (pend_v_q),
    .push_data_i(pend_q),
    .pop_i      (rd_i),
    .full_o     (full),
    .empty_o    (empty),
    .head_o     (head)
  );

  // completed char waits here while the queue is full
  assign accept = done & ~drop_q & (~mp_mode_i | addr) & (~pend_v_q | ~full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q <= 1'b0;
      pend_q   <= '0;
      drop_q   <= 1'b0;
    end else if (!rx_en_i) begin
      pend_v_q <= 1'b0;
      pend_q   <= '0;
      drop_q   <= 1'b0;
    end else begin
      if (pend_v_q && !full) pend_v_q <= 1'b0;
      if (start) begin
        if (pend_v_q && full) begin
          pend_q.ovr <= 1'b1;
          drop_q     <= 1'b1;
        end else drop_q <= 1'b0;
      end
      if (accept) begin
        pend_v_q <= 1'b1;
        pend_q   <= fr_char;
      end
    end
  end

  assign avail_o   = ~empty;
  assign data_o    = avail_o ? head.data : 8'h00;
  assign bit9_o    = avail_o & head.b9;
  assign frm_err_o = avail_o & head.fe;
  assign par_err_o = avail_o & head.pe;
  assign ovr_o     = avail_o & head.ovr;
  assign irq_o     = avail_o & rx_ie_i;
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_en_i,
  input logic       rx_ie_i,
  input logic       rd_i,
  input logic [7:0] data_o,
  input logic       bit9_o,
  input logic       avail_o,
  input logic       frm_err_o,
  input logic       ovr_o,
  input logic       par_err_o,
  input logic       irq_o
);
  // R7
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !avail_o);

  // R11
  irq_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (avail_o && rx_ie_i));

  // R5
  flags_quiet_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avail_o |-> !(frm_err_o || ovr_o || par_err_o || bit9_o));

  // R1
  head_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_o && !rd_i && rx_en_i) |=> (avail_o && $stable({data_o, bit9_o, frm_err_o, ovr_o, par_err_o})));

  // R7
  rise_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avail_o) |-> $past(rx_en_i));
endmodule

bind serial_frame_rx serial_frame_rx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rx_en_i  (rx_en_i),
  .rx_ie_i  (rx_ie_i),
  .rd_i     (rd_i),
  .data_o   (data_o),
  .bit9_o   (bit9_o),
  .avail_o  (avail_o),
  .frm_err_o(frm_err_o),
  .ovr_o    (ovr_o),
  .par_err_o(par_err_o),
  .irq_o    (irq_o)
);

// File: tb/serial_frame_rx_test.sv
`timescale 1ns/1ps
module serial_frame_rx_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b1, tick = 1'b0, dbl = 1'b0, mp = 1'b0, ie = 1'b0;
  logic rxd = 1'b1, rd = 1'b0;
  logic [2:0] len_sel = 3'b011;
  logic [1:0] par_sel = 2'b00;
  logic [7:0] data;
  logic b9, avail, fe, ovr, pe, irq;
  int tdiv = 1;
  int errs = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(negedge clk) tick <= (tdiv == 1) ? 1'b1 : ~tick;

  serial_frame_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .tick_i(tick),
    .dbl_speed_i(dbl), .len_sel_i(len_sel), .par_sel_i(par_sel),
    .mp_mode_i(mp), .rx_ie_i(ie), .rxd_i(rxd), .rd_i(rd),
    .data_o(data), .bit9_o(b9), .avail_o(avail), .frm_err_o(fe),
    .ovr_o(ovr), .par_err_o(pe), .irq_o(irq)
  );

  typedef struct packed {
    logic [2:0] len;
    logic [1:0] par;
    logic       dbl;
    logic       bad_stop;
    logic       flip;
    logic [8:0] d;
    logic       fe;
    logic       pe;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'b011, 2'b00, 1'b0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0},
    '{3'b000, 2'b10, 1'b0, 1'b0, 1'b0, 9'h1F3, 1'b0, 1'b0},
    '{3'b001, 2'b11, 1'b1, 1'b0, 1'b1, 9'h02C, 1'b0, 1'b1},
    '{3'b010, 2'b10, 1'b0, 1'b1, 1'b0, 9'h055, 1'b1, 1'b0},
    '{3'b111, 2'b00, 1'b0, 1'b0, 1'b0, 9'h1C3, 1'b0, 1'b0},
    '{3'b111, 2'b11, 1'b1, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b0},
    '{3'b011, 2'b10, 1'b1, 1'b1, 1'b1, 9'h0FF, 1'b1, 1'b1},
    '{3'b011, 2'b01, 1'b0, 1'b0, 1'b1, 9'h081, 1'b0, 1'b0}
  };

  function automatic int nbits(input logic [2:0] c);
    case (c)
      3'b000: return 5;
      3'b001: return 6;
      3'b010: return 7;
      3'b111: return 9;
      default: return 8;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    rxd = v;
    repeat ((dbl ? 8 : 16) * tdiv) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input logic bad_stop, input logic flip, input int gap);
    int n;
    logic p;
    n = nbits(len_sel);
    p = par_sel[0];
    for (int i = 0; i < n; i++) p ^= d[i];
    if (flip) p = ~p;
    bit_out(1'b0);
    for (int i = 0; i < n; i++) bit_out(d[i]);
    if (par_sel[1]) bit_out(p);
    bit_out(~bad_stop);
    for (int i = 0; i < gap; i++) bit_out(1'b1);
  endtask

  task automatic read_one();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] mask;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state (R1, R5, R11)
    check("R1 reset avail", 16'(avail), 16'h0);
    check("R5 reset flags", {13'h0, fe, ovr, pe}, 16'h0);
    check("R5 reset data", 16'(data), 16'h0);
    check("R11 reset irq", 16'(irq), 16'h0);
    repeat (20) @(negedge clk);

    // vector table: R2 R3 R4 R8
    foreach (VECS[k]) begin
      len_sel = VECS[k].len;
      par_sel = VECS[k].par;
      dbl     = VECS[k].dbl;
      send(VECS[k].d, VECS[k].bad_stop, VECS[k].flip, 2);
      n = nbits(VECS[k].len);
      mask = (n >= 8) ? 8'hFF : 8'((1 << n) - 1);
      check($sformatf("R1 vec%0d avail", k), 16'(avail), 16'h1);
      check($sformatf("R2 vec%0d data", k), 16'(data), 16'(VECS[k].d[7:0] & mask));
      check($sformatf("R2 vec%0d bit9", k), 16'(b9), 16'((n == 9) ? VECS[k].d[8] : 1'b0));
      check($sformatf("R4 vec%0d frame err", k), 16'(fe), 16'(VECS[k].fe));
      check($sformatf("R3 vec%0d parity err", k), 16'(pe), 16'(VECS[k].pe));
      read_one();
      check($sformatf("R1 vec%0d drained", k), 16'(avail), 16'h0);
    end

    // R5 per-char flags, two entries in order, R4 back-to-back with one stop
    len_sel = 3'b011; par_sel = 2'b10; dbl = 1'b0;
    send(9'h033, 1'b0, 1'b1, 0);
    send(9'h0C4, 1'b0, 1'b0, 2);
    check("R1 first head", 16'(data), 16'h33);
    check("R5 first parity err", 16'(pe), 16'h1);
    check("R4 first no frame err", 16'(fe), 16'h0);
    read_one();
    check("R1 second head", 16'(data), 16'hC4);
    check("R5 second flags clean", {13'h0, fe, ovr, pe}, 16'h0);
    read_one();
    check("R1 empty after two", 16'(avail), 16'h0);
    check("R5 data zero empty", 16'(data), 16'h0);

    // R6 overrun
    par_sel = 2'b00;
    send(9'h011, 1'b0, 1'b0, 1);
    send(9'h022, 1'b0, 1'b0, 1);
    send(9'h033, 1'b0, 1'b0, 1);
    check("R6 no overrun yet", 16'(ovr), 16'h0);
    send(9'h044, 1'b0, 1'b0, 2);
    check("R6 head 1", 16'(data), 16'h11);
    check("R6 head 1 ovr", 16'(ovr), 16'h0);
    read_one();
    check("R6 head 2", 16'(data), 16'h22);
    check("R6 head 2 ovr", 16'(ovr), 16'h0);
    read_one();
    check("R6 head 3", 16'(data), 16'h33);
    check("R6 head 3 ovr", 16'(ovr), 16'h1);
    read_one();
    check("R6 fourth lost", 16'(avail), 16'h0);

    // R11 interrupt
    send(9'h05A, 1'b1, 1'b0, 2);
    ie = 1'b1;
    @(negedge clk);
    check("R11 irq on", 16'(irq), 16'h1);
    ie = 1'b0;
    @(negedge clk);
    check("R11 irq masked", 16'(irq), 16'h0);
    send(9'h0A6, 1'b0, 1'b0, 2);

    // R7 flush
    check("R7 pre-flush fe", 16'(fe), 16'h1);
    rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
    check("R7 flushed avail", 16'(avail), 16'h0);
    check("R7 flushed flags", {13'h0, fe, ovr, pe}, 16'h0);
    ie = 1'b1;
    @(negedge clk);
    check("R11 irq empty", 16'(irq), 16'h0);
    ie = 1'b0;
    repeat (40) @(negedge clk);

    // R9 short low pulse
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (48) @(negedge clk);
    check("R9 glitch ignored", 16'(avail), 16'h0);
    send(9'h07E, 1'b0, 1'b0, 2);
    check("R9 frame after glitch", 16'(data), 16'h7E);
    read_one();

    // R10 multiprocessor filter
    len_sel = 3'b111; mp = 1'b1;
    send(9'h042, 1'b0, 1'b0, 2);
    check("R10 data frame dropped", 16'(avail), 16'h0);
    send(9'h117, 1'b0, 1'b0, 2);
    check("R10 address kept", 16'(avail), 16'h1);
    check("R10 address data", {7'h0, b9, data}, 16'h117);
    read_one();
    mp = 1'b0;

    // R8 gated ticks, every other cycle
    len_sel = 3'b011; tdiv = 2;
    repeat (4) @(negedge clk);
    send(9'h0B9, 1'b0, 1'b0, 2);
    check("R8 half-rate ticks", 16'(data), 16'hB9);
    read_one();
    tdiv = 1;

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule